// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block generates the active-low internal power-on reset for the whole chip. It runs from a free-running local oscillator and holds the reset asserted until three conditions are met one after another: the supply comparator reports a good supply, the PCIe reference clock is seen toggling, and a fixed settling time has elapsed. Only then is the reset released.

A global reset pin, active low, overrides everything. Pulling the pin low asserts the reset output at once, without waiting for an oscillator edge, and returns the sequencer to its first step. Release of the pin is resynchronised to the oscillator, so the sequence always restarts cleanly. If the supply indication drops before release, the sequence restarts. The same applies if the reference clock stops toggling before release. Once the reset has been released, only the pin can bring it back.

The oscillator frequency in MHz, the settling time in microseconds, the toggle count that marks the clock as active and the loss timeout are parameters. A two-bit state output exposes the sequence step.

Top module: `por_sequencer`

## Requirements
- R1: While `grst_n` is low, `por_n` is 0. After the pin has been low for at least three oscillator cycles, `seq_state` reads 0 (waiting for supply).
- R2: While `supply_ok` is low, the sequencer stays in state 0 and `por_n` stays 0, whatever the reference clock does.
- R3: Once the supply is good, the sequencer moves to state 1 (waiting for clock). It stays there, with `por_n` low, for as long as the reference clock is stopped.
- R4: The sequencer enters state 2 (settling delay) only from state 1. It does so only after at least `TOGGLES_NEEDED` (default 8) rising edges of `ref_clk` have occurred since clock monitoring began.
- R5: State 2 lasts exactly `OSC_MHZ*DELAY_US` oscillator cycles (default 1000 cycles, which is 10 µs at 100 MHz). The sequencer then enters state 3 (run).
- R6: In state 3, `por_n` is 1 while `grst_n` is high.
- R7: A falling edge on `grst_n` drives `por_n` to 0 within the same oscillator cycle, before the next oscillator edge.
- R8: After `grst_n` rises, `por_n` stays 0 for at least three oscillator cycles, and the sequence restarts from state 0.
- R9: If `supply_ok` falls during state 1 or state 2, the sequencer returns to state 0.
- R10: If the reference clock stops toggling during state 2 for `LOSS_TIMEOUT` oscillator cycles (default 64), the sequencer returns to state 0.
- R11: In state 3, a loss of supply or of the reference clock has no effect: the state stays 3 and `por_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Always-on local oscillator clock |
| grst_n | input | 1 | Global reset pin, active low, asynchronous assertion |
| supply_ok | input | 1 | Supply-good indication from the external comparator |
| ref_clk | input | 1 | Reference clock being monitored |
| por_n | output | 1 | Internal power-on reset, active low |
| seq_state | output | 2 | Sequence step: 0 supply wait, 1 clock wait, 2 delay, 3 run |

## Verification
If a state is wrong, it appears on `seq_state` within one oscillator cycle, and for a release it also appears on `por_n`. The bench records every change of the state output against an ordered list of expected steps, so a skipped, repeated or premature step is caught at the first transition where it happens. A settling counter with the wrong terminal value shows up as a run state that arrives early or late, measured to the exact cycle. A missing restart shows up as a state that stays put when it should have dropped back. That becomes visible only after the loss timeout, so the bench waits well past it.

// File: rtl/por_pkg.sv
// Package por_pkg
// Purpose : shared state encoding and derived constants for the
//           power-on reset sequencer.
// Assumes : encoding values are visible on the seq_state port.
package por_pkg;

    typedef enum logic [1:0] {
        ST_SUPPLY = 2'd0,
        ST_CLKWT  = 2'd1,
        ST_SETTLE = 2'd2,
        ST_RUN    = 2'd3
    } por_state_t;

    // Oscillator cycles spent in the settling delay.
    function automatic int unsigned settle_cycles(input int unsigned mhz,
                                                  input int unsigned usec);
        return mhz * usec;
    endfunction

endpackage

// File: rtl/por_rst_bridge.sv
// Module  por_rst_bridge
// Purpose : reset bridge for the global reset pin. Assertion clears the
//           chain at once; release ripples through STAGES flops.
// Assumes : pin_n may change at any time relative to clk.
module por_rst_bridge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain;

    // Shift ones in while the pin is high; clear immediately when it drops.
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_n = chain[STAGES-1];

    // Release of the bridge output only follows a cycle with the pin high.
    p_release_sync_r8: assert property (@(posedge clk) disable iff (!pin_n)
        $rose(rst_n) |-> $past(pin_n));

endmodule

// File: rtl/por_clk_detect.sv
// Module  por_clk_detect
// Purpose : judges whether ref_clk is toggling. A divide-by-two flop in
//           the reference domain is synchronised into the oscillator
//           domain. Each observed change counts one reference edge.
// Assumes : oscillator at least 2.5x faster than the reference clock;
//           detector is held cleared while enable is low.
module por_clk_detect #(
    parameter int TOGGLES_NEEDED = 8,
    parameter int LOSS_TIMEOUT   = 64,
    parameter int SYNC_STAGES    = 2
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic grst_n,
    input  logic ref_clk,
    input  logic enable,
    output logic active
);
    localparam int CW = $clog2(TOGGLES_NEEDED + 1);
    localparam int TW = $clog2(LOSS_TIMEOUT + 1);

    logic               ref_tog;
    logic [SYNC_STAGES:0] tog_sync;
    logic               seen;
    logic [CW-1:0]      tog_cnt;
    logic [TW-1:0]      idle_cnt;

    // Reference-domain toggle flop, cleared by the pin.
    always_ff @(posedge ref_clk or negedge grst_n) begin
        if (!grst_n) ref_tog <= 1'b0;
        else         ref_tog <= ~ref_tog;
    end

    // Bring the toggle into the oscillator domain, one extra flop for edge.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) tog_sync <= '0;
        else        tog_sync <= {tog_sync[SYNC_STAGES-1:0], ref_tog};
    end

    assign seen = tog_sync[SYNC_STAGES] ^ tog_sync[SYNC_STAGES-1];

    // Count toggles up to the limit; a long idle gap clears the count.
    always_ff @(posedge osc_clk) begin
        if (!rst_n || !enable) begin
            tog_cnt  <= '0;
            idle_cnt <= '0;
        end else if (seen) begin
            idle_cnt <= '0;
            if (tog_cnt != CW'(TOGGLES_NEEDED)) tog_cnt <= tog_cnt + 1'b1;
        end else if (idle_cnt == TW'(LOSS_TIMEOUT - 1)) begin
            idle_cnt <= '0;
            tog_cnt  <= '0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign active = (tog_cnt == CW'(TOGGLES_NEEDED));

    // Toggle count never exceeds the activity threshold.
    p_cnt_bound_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        tog_cnt <= CW'(TOGGLES_NEEDED));

    // Detector reports nothing in the cycle after being disabled.
    p_disable_clears_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !enable |=> !active);

endmodule

// File: rtl/por_settle_timer.sv
// Module  por_settle_timer
// Purpose : counts oscillator cycles while run is high and flags the last
//           cycle of the settling window.
// Assumes : run drops for at least one cycle between windows.
module por_settle_timer #(
    parameter int TERM = 1000
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int W = $clog2(TERM + 1);

    logic [W-1:0] cnt;

    // Free count inside the window, parked at zero outside it.
    always_ff @(posedge osc_clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!last)     cnt <= cnt + 1'b1;
    end

    assign last = run && (cnt == W'(TERM - 1));

    // Counter stays inside the window.
    p_cnt_in_window_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
        cnt <= W'(TERM - 1));

endmodule

// File: rtl/por_sequencer.sv
// Module  por_sequencer
// Purpose : releases the internal power-on reset after supply good,
//           reference clock active and a settling delay, in that order.
//           The global reset pin forces the output low asynchronously.
// Assumes : osc_clk always runs; supply_ok is asynchronous.
module por_sequencer #(
    parameter int OSC_MHZ        = 100,
    parameter int DELAY_US       = 10,
    parameter int TOGGLES_NEEDED = 8,
    parameter int LOSS_TIMEOUT   = 64,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       osc_clk,
    input  logic       grst_n,
    input  logic       supply_ok,
    input  logic       ref_clk,
    output logic       por_n,
    output logic [1:0] seq_state
);
    import por_pkg::*;

    localparam int TERM = int'(settle_cycles(OSC_MHZ, DELAY_US));

    logic                   rst_n;
    logic [SYNC_STAGES-1:0] sup_sync;
    logic                   sup_good;
    logic                   clk_active;
    logic                   settle_last;
    por_state_t             state, state_nx;

    por_rst_bridge #(.STAGES(SYNC_STAGES)) u_bridge (
        .clk   (osc_clk),
        .pin_n (grst_n),
        .rst_n (rst_n)
    );

    // Synchronise the comparator output into the oscillator domain.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) sup_sync <= '0;
        else        sup_sync <= {sup_sync[SYNC_STAGES-2:0], supply_ok};
    end
    assign sup_good = sup_sync[SYNC_STAGES-1];

    por_clk_detect #(
        .TOGGLES_NEEDED (TOGGLES_NEEDED),
        .LOSS_TIMEOUT   (LOSS_TIMEOUT),
        .SYNC_STAGES    (SYNC_STAGES)
    ) u_det (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .grst_n  (grst_n),
        .ref_clk (ref_clk),
        .enable  (state != ST_SUPPLY),
        .active  (clk_active)
    );

    por_settle_timer #(.TERM(TERM)) u_tmr (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .run     (state == ST_SETTLE),
        .last    (settle_last)
    );

    // Next-step decision for the release sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SUPPLY: if (sup_good) state_nx = ST_CLKWT;
            ST_CLKWT: begin
                if (!sup_good)       state_nx = ST_SUPPLY;
                else if (clk_active) state_nx = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!sup_good || !clk_active) state_nx = ST_SUPPLY;
                else if (settle_last)         state_nx = ST_RUN;
            end
            ST_RUN:    state_nx = ST_RUN;
            default:   state_nx = ST_SUPPLY;
        endcase
    end

    // Sequence register, returned to the supply wait by the bridged reset.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) state <= ST_SUPPLY;
        else        state <= state_nx;
    end

    assign seq_state = state;
    assign por_n     = (state == ST_RUN) && grst_n;

    // Supply gate: no progress without a good supply.
    p_supply_gate_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (state == ST_SUPPLY && !sup_good) |=> state == ST_SUPPLY);

    // Ordering: delay is only reached from the clock wait.
    p_order_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(state == ST_SETTLE) |-> $past(state) == ST_CLKWT);

    // Run is only reached from the delay.
    p_run_entry_r5: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> $past(state) == ST_SETTLE);

    // Once released, the sequence holds until the pin acts.
    p_run_sticky_r11: assert property (@(posedge osc_clk) disable iff (!rst_n)
        state == ST_RUN |=> state == ST_RUN);

    // Supply loss before release drops back to the supply wait.
    p_supply_loss_r9: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (state != ST_RUN && !sup_good) |=> state == ST_SUPPLY);

endmodule

// File: tb/sim_por_sequencer.sv
// Bench sim_por_sequencer: scoreboard of expected state steps, a monitor
// comparing each change of seq_state, and direct port checks.
module sim_por_sequencer;

    localparam int TERM = 1000;

    logic       osc_clk   = 1'b0;
    logic       grst_n    = 1'b0;
    logic       supply_ok = 1'b0;
    logic       ref_clk   = 1'b0;
    logic       ref_en    = 1'b0;
    logic       por_n;
    logic [1:0] seq_state;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cyc    = 0;
    int ref_edges = 0;
    logic       mon_on     = 1'b0;
    logic       chk_edges  = 1'b0;
    logic [1:0] last_st    = 2'd0;
    int         settle_at  = 0;
    logic [1:0] exp_q[$];

    por_sequencer u0 (
        .osc_clk   (osc_clk),
        .grst_n    (grst_n),
        .supply_ok (supply_ok),
        .ref_clk   (ref_clk),
        .por_n     (por_n),
        .seq_state (seq_state)
    );

    always #5 osc_clk = ~osc_clk;

    // Gated 50 ns reference clock.
    always begin
        if (ref_en) #25 ref_clk = ~ref_clk;
        else        #5;
    end

    always @(posedge ref_clk) ref_edges++;

    task automatic check(input string req, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic push(input logic [1:0] s);
        exp_q.push_back(s);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge osc_clk);
    endtask

    task automatic wait_state(input logic [1:0] s, input int limit);
        for (int i = 0; i < limit && seq_state !== s; i++) @(negedge osc_clk);
    endtask

    // Monitor: each change of the state output is compared with the queue.
    always @(negedge osc_clk) begin
        cyc++;
        if (mon_on && seq_state !== last_st) begin
            if (exp_q.size() == 0) begin
                check("R1-seq unexpected step", int'(seq_state), -1);
            end else begin
                check("R4 step order", int'(seq_state), int'(exp_q.pop_front()));
            end
            if (seq_state === 2'd2) begin
                settle_at = cyc;
                if (chk_edges) check("R4 toggles before delay", int'(ref_edges >= 8), 1);
            end
            if (seq_state === 2'd3 && last_st === 2'd2)
                check("R5 delay length", cyc - settle_at, TERM);
            last_st = seq_state;
        end
    end

    // Watchdog: counts as a failure and still reaches the summary.
    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: pin held low from power-up
        cycles(5);
        check("R1 por_n in reset", int'(por_n), 0);
        check("R1 state in reset", int'(seq_state), 0);
        last_st = 2'd0;
        mon_on  = 1'b1;

        // R2: supply low, clock running
        @(negedge osc_clk); #2 grst_n = 1'b1;
        cycles(10);
        ref_en = 1'b1;
        cycles(60);
        check("R2 state with supply low", int'(seq_state), 0);
        check("R2 por_n with supply low", int'(por_n), 0);

        // R3: supply good, clock stopped
        ref_en = 1'b0;
        cycles(10);
        push(2'd1);
        @(negedge osc_clk); #2 supply_ok = 1'b1;
        cycles(200);
        check("R3 state without clock", int'(seq_state), 1);
        check("R3 por_n without clock", int'(por_n), 0);

        // R4/R5/R6: clock starts, delay, release
        push(2'd2); push(2'd3);
        chk_edges = 1'b1;
        ref_edges = 0;
        ref_en    = 1'b1;
        wait_state(2'd3, 3000);
        chk_edges = 1'b0;
        cycles(2);
        check("R6 state released", int'(seq_state), 3);
        check("R6 por_n released", int'(por_n), 1);

        // R11: losses after release have no effect
        @(negedge osc_clk); #2 supply_ok = 1'b0;
        ref_en = 1'b0;
        cycles(200);
        check("R11 state after losses", int'(seq_state), 3);
        check("R11 por_n after losses", int'(por_n), 1);
        supply_ok = 1'b1;
        ref_en    = 1'b1;
        cycles(5);

        // R7: asynchronous assertion by the pin
        push(2'd0);
        @(negedge osc_clk); #2 grst_n = 1'b0;
        #1 check("R7 por_n same cycle", int'(por_n), 0);
        cycles(5);
        check("R1 state after pin", int'(seq_state), 0);

        // R8: synchronous release, sequence restarts
        push(2'd1); push(2'd2);
        @(negedge osc_clk); #2 grst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge osc_clk);
            check("R8 por_n held after release", int'(por_n), 0);
        end
        wait_state(2'd2, 500);
        cycles(100);

        // R9: supply loss during the delay
        push(2'd0);
        @(negedge osc_clk); #2 supply_ok = 1'b0;
        cycles(20);
        check("R9 state after supply loss", int'(seq_state), 0);
        check("R9 por_n after supply loss", int'(por_n), 0);

        // R10: clock loss during the delay
        push(2'd1); push(2'd2); push(2'd0); push(2'd1);
        @(negedge osc_clk); #2 supply_ok = 1'b1;
        wait_state(2'd2, 500);
        cycles(50);
        ref_en = 1'b0;
        cycles(300);
        check("R10 state after clock loss", int'(seq_state), 1);
        check("R10 por_n after clock loss", int'(por_n), 0);

        // Recovery to release once more
        push(2'd2); push(2'd3);
        ref_en = 1'b1;
        wait_state(2'd3, 3000);
        cycles(2);
        check("R6 release after recovery", int'(por_n), 1);
        check("R4 scoreboard drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule